// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps wall-clock time and a calendar in a small bank of byte-wide registers. A one-second strobe from an external prescaler advances seconds, minutes, hours, weekday, date, month and year. Carries propagate through the whole chain, and each month has its proper length. Software sees every field in packed BCD through a byte read/write port with a 3-bit address. The port gives combinational read data and registered writes.

Each write is first decoded from BCD, using only the bits that belong to the field. It then goes through a range check, and a value outside the range is dropped without changing the field. A halt flag in the seconds register freezes the count. When the flag is cleared, counting continues from the frozen value. A one-second strobe that arrives while the port is in use is held back and applied in the first cycle without an access, so a read never sees a field change partway through. The parameter `YEAR_OFFSET` gives the calendar year that a stored year of 00 stands for, counted from 1900. The default 68 makes 00 mean 1968, and 0 makes it mean 1900. The leap-year test uses the offset year.

Top module: `rtc_bcd_bank`

Register map (address: field): 0 control, 1 seconds (bit 7 = halt), 2 minutes, 3 hours, 4 day (bits 2:0 weekday, bit 6 century), 5 date, 6 month, 7 year.

## Requirements
- R1: After reset the registers read control 0x90, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00.
- R2: Each `sec_tick` pulse, in a cycle without an access and with the halt flag clear, advances the seconds by one. A read of address 1 returns the halt flag in bit 7 and the BCD seconds in bits 6:0.
- R3: Seconds 59 wraps to 00 and increments minutes. Minutes 59 wraps and increments hours. Hours 23 wraps to 00 and increments both the date and the weekday. The weekday counts 1 to 7, and 7 (or 0) steps to 1.
- R4: A date equal to the month length wraps to 01 and increments the month. Months 4, 6, 9 and 11 have 30 days, and the other months have 31 days except February. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R5: While the halt flag (seconds bit 7) is set, no field advances. Once it is cleared, counting resumes from the frozen value.
- R6: A write to seconds or minutes decodes bits 6:0 as tens (bits 6:4) times ten plus units (bits 3:0), and the field takes that value only if it lies in 0..59. A write to seconds always updates the halt flag from bit 7. A write to hours decodes bits 5:0 the same way, and the field takes the value only if it lies in 0..23. A rejected value leaves the field unchanged, and every read returns normalised BCD.
- R7: A write to date decodes bits 4:0 and is accepted when the result is nonzero. A write to month decodes bits 4:0 and is accepted in 1..12. A write to year decodes all 8 bits and is accepted in 0..99.
- R8: A write to the day register loads the weekday from bits 2:0 and the century flag from bit 6. Reads of that register return zero in bits 7, 5, 4 and 3.
- R9: A write to control stores the byte with bits 7 and 4 forced to 1 and bit 5 forced to 0.
- R10: A tick that arrives in a cycle with `acc_en` high is applied in the first following cycle with `acc_en` low. During the access the read data shows the time from before the tick, and a value written in that access is the value the deferred tick advances.
- R11: February has 29 days when (`YEAR_OFFSET` + stored year) is divisible by 4 and 28 days otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| acc_en | input | 1 | Register access in this cycle |
| acc_we | input | 1 | Access is a write when high |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for `acc_addr` (combinational) |

## Verification
The one-second advance and a register access can fall in the same cycle. This can corrupt a read across a carry, or let a write and an increment both act on one field. The bench raises `sec_tick` during a read held over two cycles and checks that both samples show the old seconds and that the increment appears only after the port goes idle. It also pulses the tick together with writes to seconds and minutes, and checks that the written seconds value comes back plus one while the written minutes value is unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_SEC   = 3'd1,
        REG_MIN   = 3'd2,
        REG_HOUR  = 3'd3,
        REG_DAY   = 3'd4,
        REG_DATE  = 3'd5,
        REG_MONTH = 3'd6,
        REG_YEAR  = 3'd7
    } rtc_reg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic              halt;
        logic [5:0]        sec;
        logic [5:0]        min;
        logic [4:0]        hour;
        logic [2:0]        wday;
        logic              cent;
        logic [4:0]        date;
        logic [3:0]        month;
        logic [6:0]        year;
    } rtc_time_t;

    // Packed BCD byte to binary (tens nibble times ten plus units nibble).
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'b0000, v[7:4]} * 8'd10) + {4'b0000, v[3:0]};
    endfunction

    // Binary 0..99 to packed BCD.
    function automatic logic [7:0] bin_to_bcd(input logic [6:0] n);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = n / 7'd10;
        units = n - (tens * 7'd10);
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [4:0] days_in_month(input logic [3:0] m, input logic leap);
        logic [4:0] len;
        case (m)
            4'd2:                       len = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    len = 5'd30;
            default:                    len = 5'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic busy_i,
    output logic adv_o
);

    typedef struct packed {
        logic pend;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        adv_o = 1'b0;
        if (busy_i) begin
            st_d.pend = st_q.pend | tick_i;
        end else begin
            adv_o     = st_q.pend | tick_i;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: a tick seen during an access is remembered
    assert_tick_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && busy_i) |=> st_q.pend);

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int YEAR_OFFSET = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output rtc_time_t         state_o
);

    localparam logic [1:0]        OFS_LO   = 2'(YEAR_OFFSET % 4);
    localparam logic [BYTE_W-1:0] CTRL_SET = 8'h90;
    localparam logic [BYTE_W-1:0] CTRL_CLR = 8'h20;
    localparam rtc_time_t RESET_VAL = '{
        ctrl: CTRL_SET, halt: 1'b0, sec: '0, min: '0, hour: '0,
        wday: 3'd1, cent: 1'b0, date: 5'd1, month: 4'd1, year: '0
    };

    rtc_time_t st_d, st_q;
    logic [1:0] ysum;
    logic       leap;
    logic [4:0] mlen;
    logic [7:0] dv;

    always_comb begin
        st_d = st_q;
        dv   = '0;
        ysum = st_q.year[1:0] + OFS_LO;
        leap = (ysum == 2'd0);
        mlen = days_in_month(st_q.month, leap);

        // calendar advance
        if (adv_i && !st_q.halt) begin
            if (st_q.sec >= 6'd59) begin
                st_d.sec = '0;
                if (st_q.min >= 6'd59) begin
                    st_d.min = '0;
                    if (st_q.hour >= 5'd23) begin
                        st_d.hour = '0;
                        st_d.wday = (st_q.wday >= 3'd7 || st_q.wday == 3'd0) ? 3'd1 : st_q.wday + 3'd1;
                        if (st_q.date >= mlen) begin
                            st_d.date = 5'd1;
                            if (st_q.month >= 4'd12) begin
                                st_d.month = 4'd1;
                                st_d.year  = (st_q.year >= 7'd99) ? 7'd0 : st_q.year + 7'd1;
                            end else begin
                                st_d.month = st_q.month + 4'd1;
                            end
                        end else begin
                            st_d.date = st_q.date + 5'd1;
                        end
                    end else begin
                        st_d.hour = st_q.hour + 5'd1;
                    end
                end else begin
                    st_d.min = st_q.min + 6'd1;
                end
            end else begin
                st_d.sec = st_q.sec + 6'd1;
            end
        end

        // register writes with per-field range checks
        if (wr_en_i) begin
            unique case (rtc_reg_e'(waddr_i))
                REG_CTRL: st_d.ctrl = (wdata_i & ~CTRL_CLR) | CTRL_SET;
                REG_SEC: begin
                    dv = bcd_to_bin(wdata_i & 8'h7F);
                    if (dv <= 8'd59) st_d.sec = dv[5:0];
                    st_d.halt = wdata_i[7];
                end
                REG_MIN: begin
                    dv = bcd_to_bin(wdata_i & 8'h7F);
                    if (dv <= 8'd59) st_d.min = dv[5:0];
                end
                REG_HOUR: begin
                    dv = bcd_to_bin(wdata_i & 8'h3F);
                    if (dv <= 8'd23) st_d.hour = dv[4:0];
                end
                REG_DAY: begin
                    st_d.wday = wdata_i[2:0];
                    st_d.cent = wdata_i[6];
                end
                REG_DATE: begin
                    dv = bcd_to_bin(wdata_i & 8'h1F);
                    if (dv != 8'd0) st_d.date = dv[4:0];
                end
                REG_MONTH: begin
                    dv = bcd_to_bin(wdata_i & 8'h1F);
                    if (dv >= 8'd1 && dv <= 8'd12) st_d.month = dv[3:0];
                end
                REG_YEAR: begin
                    dv = bcd_to_bin(wdata_i);
                    if (dv <= 8'd99) st_d.year = dv[6:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_VAL;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    assert_ctrl_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl[7] && st_q.ctrl[4] && !st_q.ctrl[5]);

    assert_time_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sec < 6'd60) && (st_q.min < 6'd60) && (st_q.hour < 5'd24));

    assert_date_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.month >= 4'd1) && (st_q.month <= 4'd12) && (st_q.date != 5'd0) && (st_q.year <= 7'd99));

    assert_halt_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.halt && !wr_en_i) |=> ($stable(st_q.sec) && $stable(st_q.min) && $stable(st_q.hour)
                                     && $stable(st_q.date) && $stable(st_q.month) && $stable(st_q.year)));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !adv_i) |=> $stable(st_q));

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
(
    input  rtc_time_t         state_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BYTE_W-1:0] rdata_o
);

    logic [7:0] b_sec, b_min, b_hour, b_date, b_month, b_year;

    always_comb begin
        b_sec   = bin_to_bcd({1'b0, state_i.sec});
        b_min   = bin_to_bcd({1'b0, state_i.min});
        b_hour  = bin_to_bcd({2'b00, state_i.hour});
        b_date  = bin_to_bcd({2'b00, state_i.date});
        b_month = bin_to_bcd({3'b000, state_i.month});
        b_year  = bin_to_bcd(state_i.year);
        unique case (rtc_reg_e'(addr_i))
            REG_CTRL:  rdata_o = state_i.ctrl;
            REG_SEC:   rdata_o = {state_i.halt, 7'b0} | b_sec;
            REG_MIN:   rdata_o = b_min;
            REG_HOUR:  rdata_o = b_hour;
            REG_DAY:   rdata_o = {1'b0, state_i.cent, 3'b000, state_i.wday};
            REG_DATE:  rdata_o = b_date;
            REG_MONTH: rdata_o = b_month;
            REG_YEAR:  rdata_o = b_year;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_bank.sv
module rtc_bcd_bank
    import rtc_pkg::*;
#(
    parameter int YEAR_OFFSET = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic [BYTE_W-1:0] acc_rdata
);

    logic      adv;
    logic      wr_en;
    rtc_time_t cur;

    assign wr_en = acc_en & acc_we;

    rtc_tick_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sec_tick),
        .busy_i (acc_en),
        .adv_o  (adv)
    );

    rtc_time_core #(.YEAR_OFFSET(YEAR_OFFSET)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .wr_en_i (wr_en),
        .waddr_i (acc_addr),
        .wdata_i (acc_wdata),
        .state_o (cur)
    );

    rtc_read_mux u_rmux (
        .state_i (cur),
        .addr_i  (acc_addr),
        .rdata_o (acc_rdata)
    );

    // R10: the calendar never moves in a cycle that carries an access
    assert_no_adv_in_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> $stable(cur));

endmodule

// File: tb/sim_rtc_bcd_bank.sv
module sim_rtc_bcd_bank;

    localparam logic [2:0] A_CTRL = 3'd0, A_SEC = 3'd1, A_MIN = 3'd2, A_HOUR = 3'd3,
                           A_DAY = 3'd4, A_DATE = 3'd5, A_MON = 3'd6, A_YEAR = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_we = 1'b0;
    logic [2:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd0, rd1;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rtc_bcd_bank u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(rd0));

    rtc_bcd_bank #(.YEAR_OFFSET(1)) u1 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(rd1));

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int dec(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int mlen(input int m, input int y, input int ofs);
        if (m == 2) return (((y + ofs) % 4) == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d0, output logic [7:0] d1);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #2;
        d0 = rd0; d1 = rd1;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // write sweep over all 256 byte values of one field
    task automatic sweep(input string tag, input logic [2:0] a, input logic [7:0] mask,
                         input int lo, input int hi, input bit keep_halt, input int start);
        int prev;
        logic [7:0] d0, d1, exp;
        prev = start;
        for (int v = 0; v < 256; v++) begin
            int dv;
            wr(a, 8'(v));
            dv = dec(8'(v) & mask);
            if (dv >= lo && dv <= hi) prev = dv;
            exp = bcd(prev);
            if (keep_halt) exp = exp | (8'(v) & 8'h80);
            rd(a, d0, d1);
            chk(tag, d0, exp);
        end
    endtask

    // per-instance calendar model for the day-rollover sweep
    int m_date[2], m_mon[2], m_year[2], m_wday[2];
    int ofs[2] = '{68, 1};

    task automatic roll_day(input int m_cur);
        logic [7:0] d0, d1;
        wr(A_HOUR, 8'h23);
        wr(A_MIN, 8'h59);
        wr(A_SEC, 8'h59);
        tick();
        for (int k = 0; k < 2; k++) begin
            m_wday[k] = (m_wday[k] >= 7 || m_wday[k] == 0) ? 1 : m_wday[k] + 1;
            if (m_date[k] >= mlen(m_mon[k], m_year[k], ofs[k])) begin
                m_date[k] = 1;
                if (m_mon[k] == 12) begin
                    m_mon[k] = 1;
                    m_year[k] = (m_year[k] == 99) ? 0 : m_year[k] + 1;
                end else m_mon[k] = m_mon[k] + 1;
            end else m_date[k] = m_date[k] + 1;
        end
        rd(A_DATE, d0, d1);
        chk((m_cur == 2) ? "R4 feb date" : "R4 date", d0, bcd(m_date[0]));
        chk((m_cur == 2) ? "R11 feb date" : "R4 date (offset 1)", d1, bcd(m_date[1]));
        rd(A_MON, d0, d1);
        chk("R4 month", d0, bcd(m_mon[0]));
        chk("R11 month", d1, bcd(m_mon[1]));
        rd(A_YEAR, d0, d1);
        chk("R4 year", d0, bcd(m_year[0]));
        chk("R11 year", d1, bcd(m_year[1]));
        rd(A_DAY, d0, d1);
        chk("R3 weekday", d0, 8'(8'h40 | m_wday[0]));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d0, d1;
        logic [7:0] exp_rst [8];
        exp_rst = '{8'h90, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d0, d1);
            chk("R1 reset value", d0, exp_rst[a]);
        end

        // R9 control forcing, exhaustive
        for (int v = 0; v < 256; v++) begin
            wr(A_CTRL, 8'(v));
            rd(A_CTRL, d0, d1);
            chk("R9 control", d0, (8'(v) & 8'hDF) | 8'h90);
        end

        // R6 / R7 range-checked writes, exhaustive
        sweep("R6 seconds", A_SEC, 8'h7F, 0, 59, 1'b1, 0);
        wr(A_SEC, 8'h00);
        sweep("R6 minutes", A_MIN, 8'h7F, 0, 59, 1'b0, 0);
        sweep("R6 hours", A_HOUR, 8'h3F, 0, 23, 1'b0, 0);
        sweep("R7 date", A_DATE, 8'h1F, 1, 255, 1'b0, 1);
        sweep("R7 month", A_MON, 8'h1F, 1, 12, 1'b0, 1);
        sweep("R7 year", A_YEAR, 8'hFF, 0, 99, 1'b0, 0);

        // R8 day register, exhaustive
        for (int v = 0; v < 256; v++) begin
            wr(A_DAY, 8'(v));
            rd(A_DAY, d0, d1);
            chk("R8 day register", d0, (8'(v) & 8'h40) | (8'(v) & 8'h07));
        end

        // R2 / R3 seconds counting across a full minute
        wr(A_HOUR, 8'h09);
        wr(A_MIN, 8'h59);
        wr(A_SEC, 8'h00);
        for (int i = 1; i <= 60; i++) begin
            tick();
            rd(A_SEC, d0, d1);
            chk("R2 seconds tick", d0, bcd(i % 60));
        end
        rd(A_MIN, d0, d1);
        chk("R3 minute wrap", d0, 8'h00);
        rd(A_HOUR, d0, d1);
        chk("R3 hour carry 09->10", d0, 8'h10);

        // R3 midnight clears time fields
        wr(A_DAY, 8'h07);
        wr(A_DATE, 8'h05);
        wr(A_HOUR, 8'h23);
        wr(A_MIN, 8'h59);
        wr(A_SEC, 8'h59);
        tick();
        rd(A_HOUR, d0, d1); chk("R3 midnight hour", d0, 8'h00);
        rd(A_MIN, d0, d1);  chk("R3 midnight minute", d0, 8'h00);
        rd(A_SEC, d0, d1);  chk("R3 midnight second", d0, 8'h00);
        rd(A_DATE, d0, d1); chk("R3 date carry", d0, 8'h06);
        rd(A_DAY, d0, d1);  chk("R3 weekday 7->1", d0, 8'h01);

        // R5 halt and resume
        wr(A_SEC, 8'h90);
        for (int i = 0; i < 5; i++) tick();
        rd(A_SEC, d0, d1); chk("R5 halted seconds", d0, 8'h90);
        rd(A_MIN, d0, d1); chk("R5 halted minutes", d0, 8'h00);
        wr(A_SEC, 8'h10);
        tick();
        rd(A_SEC, d0, d1); chk("R5 resume from frozen", d0, 8'h11);

        // R10 tick during a two-cycle read is deferred
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = A_SEC; sec_tick = 1'b1;
        #2 chk("R10 read during tick", rd0, 8'h11);
        @(negedge clk);
        sec_tick = 1'b0;
        #2 chk("R10 still deferred", rd0, 8'h11);
        @(negedge clk);
        acc_en = 1'b0;
        @(negedge clk);
        rd(A_SEC, d0, d1); chk("R10 applied after access", d0, 8'h12);

        // R10 tick coinciding with writes
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = A_SEC; acc_wdata = 8'h30; sec_tick = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0; sec_tick = 1'b0;
        @(negedge clk);
        rd(A_SEC, d0, d1); chk("R10 write then deferred tick", d0, 8'h31);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = A_MIN; acc_wdata = 8'h20; sec_tick = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0; sec_tick = 1'b0;
        @(negedge clk);
        rd(A_MIN, d0, d1); chk("R10 minute kept", d0, 8'h20);
        rd(A_SEC, d0, d1); chk("R10 second advanced", d0, 8'h32);

        // R4 / R11 month lengths, leap years and year wrap
        wr(A_DAY, 8'h47);
        for (int k = 0; k < 2; k++) m_wday[k] = 7;
        foreach (ofs[k]) begin end
        for (int yi = 0; yi < 4; yi++) begin
            int yv;
            yv = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 3 : 99;
            for (int m = 1; m <= 12; m++) begin
                wr(A_YEAR, bcd(yv));
                wr(A_MON, bcd(m));
                wr(A_DATE, 8'h19);
                for (int k = 0; k < 2; k++) begin
                    m_year[k] = yv; m_mon[k] = m; m_date[k] = 19;
                end
                for (int r = 0; r < 13; r++) roll_day(m);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule